// File: doc/BRIEF.md
# Dual-Channel Sample Pair Recovery

This block sits in the receive logic behind a dual-channel 14-bit converter. The converter drives two output buses. Each bus carries a 14-bit word (bit 13 is the MSB) and one out-of-range flag. A bus-select line decides which channel each bus carries. With the select line high, channel A is on bus A and channel B is on bus B. With the select line low, the two are exchanged. The block runs on a fast system clock and takes the converter's sample clock in as an ordinary input. It synchronises that clock, finds its rising and falling edges, and captures the bus words that were present during the phase that has just ended.

The block has two operating modes. In multiplexed mode the select line and the sample clock are the same signal. Bus A then presents one channel while the clock is high and the other channel while it is low. The block keeps the word from the high phase, combines it with the word from the following low phase, and delivers the two together as one aligned pair. In separate-bus mode both buses are captured together at each rising edge of the sample clock. In both modes a swap setting corrects the channel mapping. Each out-of-range flag stays with its own channel's word. Each pair is announced by a valid pulse one system clock wide.

Top module: `dual_bus_demux`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, both output words, both output flags and the valid strobe are zero.
- R2: Multiplexed mode with swap=0. The bus-A word seen during a sample-clock high phase is channel A. The bus-A word seen during the following low phase is channel B. The pair is emitted after the rising edge that ends that low phase.
- R3: Multiplexed mode with swap=1. The high-phase word is channel B and the low-phase word is channel A. The timing is the same as in R2.
- R4: In multiplexed mode, no pair is emitted at a rising edge unless a high-phase word has been captured since reset. A high-phase word captured before a reset is discarded by that reset.
- R5: Separate-bus mode with swap=0. Bus A is channel A and bus B is channel B. Both buses are captured at each sample-clock rising edge, as the values held just before that edge, and one pair is emitted per rising edge.
- R6: Separate-bus mode with swap=1. Bus A is channel B and bus B is channel A.
- R7: Each out-of-range flag is delivered on the output flag of the channel whose word it came with, in every mode and swap setting.
- R8: The valid strobe is high for exactly one system cycle per pair. The output words and flags do not change in any cycle where valid is low.
- R9: In multiplexed mode the contents of bus B have no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| mux_mode | input | 1 | 1 = multiplexed mode, 0 = separate-bus mode |
| swap | input | 1 | Channel mapping correction |
| smp_clk | input | 1 | Converter sample clock, which is also the select line in multiplexed mode |
| bus_a_data | input | 14 | Bus A word |
| bus_a_ovf | input | 1 | Bus A out-of-range flag |
| bus_b_data | input | 14 | Bus B word |
| bus_b_ovf | input | 1 | Bus B out-of-range flag |
| ch_a_data | output | 14 | Channel A word of the current pair |
| ch_a_ovf | output | 1 | Channel A out-of-range flag |
| ch_b_data | output | 14 | Channel B word of the current pair |
| ch_b_ovf | output | 1 | Channel B out-of-range flag |
| pair_valid | output | 1 | One-cycle strobe marking a new pair |

## Verification
The block has little internal state, and each kind of fault shows up at the ports within one sample-clock period. A stale or uncleared held high-phase word produces either an extra pair right after reset or a pair mixing words from two periods. The first of these appears at the first rising edge. Capturing on the wrong side of an edge, or selecting the wrong buffered word, shifts every following pair by one phase. A mapping fault swaps words or flags between the channels in the very next pair.

// File: rtl/dual_bus_demux.sv
module dual_bus_demux #(
  parameter int W    = 14,
  parameter int SYNC = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         mux_mode,
  input  logic         swap,
  input  logic         smp_clk,
  input  logic [W-1:0] bus_a_data,
  input  logic         bus_a_ovf,
  input  logic [W-1:0] bus_b_data,
  input  logic         bus_b_ovf,
  output logic [W-1:0] ch_a_data,
  output logic         ch_a_ovf,
  output logic [W-1:0] ch_b_data,
  output logic         ch_b_ovf,
  output logic         pair_valid
);
  localparam int FW = W + 1;

  logic [SYNC:0]   ck_sh;
  logic [FW-1:0]   sha [0:SYNC];
  logic [FW-1:0]   shb [0:SYNC];
  logic [FW-1:0]   hi_word;
  logic            have_hi;
  logic [FW-1:0]   out_a, out_b;
  logic            valid_q;

  logic            rise, fall, emit;
  logic [FW-1:0]   cur_a, cur_b, nxt_a, nxt_b;

  // bus words are delayed as far as the clock sync, so cur_* is the value before the edge
  assign rise  = ck_sh[SYNC-1] & ~ck_sh[SYNC];
  assign fall  = ~ck_sh[SYNC-1] & ck_sh[SYNC];
  assign cur_a = sha[SYNC];
  assign cur_b = shb[SYNC];
  assign emit  = rise & (~mux_mode | have_hi);

  assign nxt_a = mux_mode ? (swap ? cur_a : hi_word) : (swap ? cur_b : cur_a);
  assign nxt_b = mux_mode ? (swap ? hi_word : cur_a) : (swap ? cur_a : cur_b);

  always_ff @(posedge clk) begin
    if (rst) begin
      ck_sh   <= '0;
      for (int i = 0; i <= SYNC; i++) begin
        sha[i] <= '0;
        shb[i] <= '0;
      end
      hi_word <= '0;
      have_hi <= 1'b0;
      out_a   <= '0;
      out_b   <= '0;
      valid_q <= 1'b0;
    end else begin
      ck_sh  <= {ck_sh[SYNC-1:0], smp_clk};
      sha[0] <= {bus_a_ovf, bus_a_data};
      shb[0] <= {bus_b_ovf, bus_b_data};
      for (int i = 1; i <= SYNC; i++) begin
        sha[i] <= sha[i-1];
        shb[i] <= shb[i-1];
      end
      valid_q <= emit;
      if (emit) begin
        out_a <= nxt_a;
        out_b <= nxt_b;
      end
      if (fall) begin
        hi_word <= cur_a;
        have_hi <= 1'b1;
      end else if (rise) begin
        have_hi <= 1'b0;
      end
    end
  end

  assign ch_a_data  = out_a[W-1:0];
  assign ch_a_ovf   = out_a[W];
  assign ch_b_data  = out_b[W-1:0];
  assign ch_b_ovf   = out_b[W];
  assign pair_valid = valid_q;

  p_rst_clear_r1: assert property (@(posedge clk)
    rst |=> (!pair_valid && ch_a_data == '0 && ch_b_data == '0 && !ch_a_ovf && !ch_b_ovf));

  p_emit_after_rise_r2: assert property (@(posedge clk) disable iff (rst)
    pair_valid |-> ck_sh[SYNC]);

  p_pair_consumed_r4: assert property (@(posedge clk) disable iff (rst)
    (pair_valid && mux_mode) |-> !have_hi);

  p_single_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    pair_valid |=> !pair_valid);

  p_hold_r8: assert property (@(posedge clk) disable iff (rst)
    !pair_valid |-> $stable({ch_a_ovf, ch_a_data, ch_b_ovf, ch_b_data}));
endmodule

// File: tb/dual_bus_demux_tb_top.sv
`timescale 1ns/1ps
module dual_bus_demux_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mux_mode = 1'b0;
  logic swap = 1'b0;
  logic smp_clk = 1'b0;
  logic [14:0] ba = '0, bb = '0;
  logic [13:0] ch_a_data, ch_b_data;
  logic ch_a_ovf, ch_b_ovf, pair_valid;

  always #2 clk = ~clk;

  dual_bus_demux dut_i (
    .clk(clk), .rst(rst), .mux_mode(mux_mode), .swap(swap), .smp_clk(smp_clk),
    .bus_a_data(ba[13:0]), .bus_a_ovf(ba[14]),
    .bus_b_data(bb[13:0]), .bus_b_ovf(bb[14]),
    .ch_a_data(ch_a_data), .ch_a_ovf(ch_a_ovf),
    .ch_b_data(ch_b_data), .ch_b_ovf(ch_b_ovf), .pair_valid(pair_valid));

  int checks = 0, errors = 0, wr = 0, rd = 0, nval = 0;
  bit done = 0;
  logic [14:0] ea [0:511];
  logic [14:0] eb [0:511];
  string etag [0:511];
  logic prev_v = 0;
  logic [29:0] last_out = '0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic push(input logic [14:0] a, input logic [14:0] b, input string tag);
    ea[wr] = a; eb[wr] = b; etag[wr] = tag; wr++;
  endtask

  always @(negedge clk) begin
    if (rst) begin
      prev_v = 0;
      last_out = '0;
    end else begin
      if (pair_valid) begin
        nval++;
        if (rd < wr) begin
          chk({ch_a_ovf, ch_a_data} == ea[rd], {etag[rd], " chanA"}, {17'd0, ch_a_ovf, ch_a_data}, {17'd0, ea[rd]});
          chk({ch_b_ovf, ch_b_data} == eb[rd], {etag[rd], " chanB"}, {17'd0, ch_b_ovf, ch_b_data}, {17'd0, eb[rd]});
          rd++;
        end else chk(0, "R4 unexpected pair", 1, 0);
        chk(!prev_v, "R8 pulse width", {31'd0, prev_v}, 0);
      end else begin
        chk({ch_a_ovf, ch_a_data, ch_b_ovf, ch_b_data} == last_out, "R8 hold",
            {2'd0, ch_a_ovf, ch_a_data, ch_b_ovf, ch_b_data}, {2'd0, last_out});
      end
      prev_v = pair_valid;
      last_out = {ch_a_ovf, ch_a_data, ch_b_ovf, ch_b_data};
    end
  end

  task automatic do_reset();
    @(negedge clk);
    smp_clk = 0; rst = 1;
    repeat (5) @(negedge clk);
    chk(!pair_valid && ch_a_data == 0 && ch_b_data == 0 && !ch_a_ovf && !ch_b_ovf, "R1 reset state",
        {1'b0, pair_valid, ch_a_ovf, ch_b_ovf, ch_a_data, ch_b_data}, 0);
    rst = 0;
    // first cycle after reset
    @(negedge clk);
    chk(!pair_valid && ch_a_data == 0 && ch_b_data == 0, "R1 post reset",
        {2'b0, pair_valid, 1'b0, ch_a_data, ch_b_data}, 0);
  endtask

  task automatic mux_cycle(input logic [14:0] hi, input logic [14:0] lo, input string tag);
    smp_clk = 1; ba = hi; bb = ~hi;
    repeat (13) @(negedge clk);
    smp_clk = 0; ba = lo; bb = lo ^ 15'h2aaa;
    repeat (13) @(negedge clk);
    push(swap ? lo : hi, swap ? hi : lo, tag);
  endtask

  task automatic sep_cycle(input logic [14:0] a, input logic [14:0] b, input string tag);
    smp_clk = 0; ba = a; bb = b;
    push(swap ? b : a, swap ? a : b, tag);
    repeat (13) @(negedge clk);
    smp_clk = 1;
    repeat (13) @(negedge clk);
  endtask

  function automatic logic [14:0] word(input int i, input int k);
    logic [13:0] d;
    case (i)
      0: d = 14'h0000;
      1: d = 14'h3fff;
      2: d = 14'h2000;
      3: d = 14'h1fff;
      default: d = 14'((i * 1237 + k * 611 + 5) % 16384);
    endcase
    return {1'((i >> k) & 1) ^ 1'(k), d};
  endfunction

  initial begin
    int n0;
    // multiplexed, swap 0
    mux_mode = 1; swap = 0;
    do_reset();
    n0 = nval;
    mux_cycle(word(0, 0), word(0, 1), "R2 R7 R9");
    chk(nval == n0, "R4 first rise after reset", nval, n0);
    for (int i = 1; i < 40; i++) mux_cycle(word(i, 0), word(i, 1), "R2 R7 R9");
    smp_clk = 1; repeat (13) @(negedge clk);
    chk(rd == wr, "R2 pair count", rd, wr);

    // reset in the middle of a pair
    do_reset();
    smp_clk = 1; ba = 15'h1234;
    repeat (13) @(negedge clk);
    smp_clk = 0; ba = 15'h4321;
    repeat (6) @(negedge clk);
    n0 = nval;
    do_reset();
    smp_clk = 1; repeat (13) @(negedge clk);
    chk(nval == n0, "R4 held word dropped by reset", nval, n0);

    // multiplexed, swap 1
    swap = 1;
    do_reset();
    for (int i = 0; i < 40; i++) mux_cycle(word(i, 2), word(i, 3), "R3 R7 R9");
    smp_clk = 1; repeat (13) @(negedge clk);
    chk(rd == wr, "R3 pair count", rd, wr);

    // separate buses
    mux_mode = 0; swap = 0;
    do_reset();
    for (int i = 0; i < 40; i++) sep_cycle(word(i, 0), word(i, 3), "R5 R7");
    chk(rd == wr, "R5 pair count", rd, wr);
    swap = 1;
    do_reset();
    for (int i = 0; i < 40; i++) sep_cycle(word(i, 1), word(i, 2), "R6 R7");
    chk(rd == wr, "R6 pair count", rd, wr);

    repeat (10) @(negedge clk);
    chk(nval == wr, "R8 one pulse per pair", nval, wr);
    if (!done) begin
      done = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", rd, wr);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule